// File: doc/BRIEF.md
# Line-Tagged Multichannel Receive Silo

This block collects received characters from up to sixteen serial line receivers into one shared first-in first-out store. Each receiver pulses a strobe together with its character and its parity and framing error indications. The block tags every stored entry with the number of the line it came from. A processor drains the store one entry per read of the character register. Each read word says whether it holds a real entry, which line the entry came from, and whether the character suffered a parity error, a framing error (break) or a lost predecessor.

Three registers are reachable through a small register port. The control/status register holds the two interrupt flags, their enables, a maintenance bit and a self-clearing master clear. The character register pops the store. The silo status register holds a programmable fill level and reports the current fill. When the fill climbs to that level, a storage interrupt is raised. This lets software take a batch of characters at once instead of one per interrupt.

Top module: `line_rx_silo`

## Requirements
- R1: When the store is empty, a read of the character register (select 1) returns 16'h0000 with bit 15 clear, and the fill stays at zero.
- R2: A popped word carries bit 15 = 1 (valid), bits 11:8 = originating line, bits 7:0 = character, bit 12 = parity error, bit 13 = framing error and bit 14 = overrun.
- R3: Entries leave in the order they were stored, and each read of the character register with the store non-empty removes exactly one entry.
- R4: A strobe is captured at the clock edge where it is high, and the entry is stored at the next edge. When several lines strobe in the same cycle, they are stored one per cycle, lowest line number first.
- R5: When the store already holds DEPTH (64) entries and no pop happens in that cycle, an entry due to be stored is discarded. The next entry later stored for that line has bit 14 set. Stored entries are not disturbed.
- R6: A new strobe on a line whose previous character has not yet been stored discards the new character. The next stored entry of that line carries bit 14, and that bit is cleared for the entry after it.
- R7: Control/status bit 7 reads 1 exactly while the store is non-empty. Bit 6 is a read/write enable. Output irqRx equals bit 7 AND bit 6.
- R8: The silo status register (select 2) takes a level in bits 6:0 and reads back that level in bits 6:0 with the fill in bits 14:8. Control/status bit 14 sets when the fill rises to a non-zero level and stays set until a control/status write with bit 14 = 0. Output irqStorage equals bit 14 AND enable bit 12.
- R9: Writing 1 to control/status bit 11 empties the store, drops held characters and overrun marks, clears every control/status bit and sets the level to zero at that edge. Bit 11 always reads 0.
- R10: Control/status bit 9 (maintenance) reads back as written. Bits 15, 13, 11, 10, 8 and 5:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStrobe | input | 16 | Per-line character-ready pulse |
| lineData | input | 128 | Per-line characters, line n in bits 8n+7:8n |
| lineParErr | input | 16 | Per-line parity error with the strobe |
| lineFrmErr | input | 16 | Per-line framing error with the strobe |
| regSel | input | 2 | Register select: 0 control/status, 1 character, 2 silo status |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops on select 1) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for the current select |
| irqRx | output | 1 | Receive interrupt request |
| irqStorage | output | 1 | Fill level interrupt request |

## Verification
A wrong fill count or pointer shows up at the very next read. The head word, or the fill field of the silo status register, departs from the bench's model on the same cycle. A stale overrun mark or a mis-ordered grant shows only when that line's next entry reaches the head, which can be up to 64 pops later. For that reason the bench drains every entry and compares whole words. A flag that sets on the wrong edge is visible one cycle later on irqRx or irqStorage.

// File: rtl/silo_pkg.sv
package silo_pkg;
  localparam int CHAR_W = 8;
  localparam int TAG_W  = 4;

  localparam logic [1:0] SEL_CSR  = 2'd0;
  localparam logic [1:0] SEL_CHAR = 2'd1;
  localparam logic [1:0] SEL_FILL = 2'd2;

  localparam int B_RIE = 6;
  localparam int B_RI  = 7;
  localparam int B_MNT = 9;
  localparam int B_MC  = 11;
  localparam int B_SIE = 12;
  localparam int B_SI  = 14;

  typedef struct packed {
    logic              ovr;
    logic              frm;
    logic              par;
    logic [TAG_W-1:0]  line;
    logic [CHAR_W-1:0] data;
  } siloEntry_t;

  typedef struct packed {
    logic pop;
    logic clear;
  } siloCmd_t;
endpackage

// File: rtl/silo_datapath.sv
module silo_datapath
  import silo_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DEPTH  = 64,
  localparam int FILL_W = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  siloCmd_t                 cmd,
  input  logic [NLINES-1:0]        lineStrobe,
  input  logic [NLINES*CHAR_W-1:0] lineData,
  input  logic [NLINES-1:0]        lineParErr,
  input  logic [NLINES-1:0]        lineFrmErr,
  output siloEntry_t               headEntry,
  output logic [FILL_W-1:0]        fill,
  output logic [FILL_W-1:0]        fillNext
);
  logic [CHAR_W-1:0] holdData [NLINES];
  logic [NLINES-1:0] holdPar, holdFrm, pending, lostFlag;
  logic [TAG_W-1:0]  grantIdx;
  logic              grantValid;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  siloEntry_t        mem [DEPTH];
  siloEntry_t        newEntry;
  logic              isFull, isEmpty, doPop, doPush, dropFull;

  // lowest pending line wins
  always_comb begin
    grantValid = 1'b0;
    grantIdx   = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        grantValid = 1'b1;
        grantIdx   = TAG_W'(i);
      end
    end
  end

  assign isFull   = (fill == FILL_W'(DEPTH));
  assign isEmpty  = (fill == '0);
  assign doPop    = cmd.pop && !isEmpty && !cmd.clear;
  assign doPush   = grantValid && (!isFull || doPop) && !cmd.clear;
  assign dropFull = grantValid && !doPush && !cmd.clear;
  assign fillNext = cmd.clear ? '0 : fill + FILL_W'(doPush) - FILL_W'(doPop);

  always_comb begin
    newEntry      = '0;
    newEntry.line = grantIdx;
    for (int i = 0; i < NLINES; i++) begin
      if (grantIdx == TAG_W'(i)) begin
        newEntry.data = holdData[i];
        newEntry.par  = holdPar[i];
        newEntry.frm  = holdFrm[i];
        newEntry.ovr  = lostFlag[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      fill <= fillNext;
      if (cmd.clear) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (doPush) wrPtr <= wrPtr + 1'b1;
        if (doPop)  rdPtr <= rdPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newEntry;
  end

  assign headEntry = mem[rdPtr];

  for (genvar g = 0; g < NLINES; g++) begin : gLine
    logic grantHit, pendAfter, collide;
    assign grantHit  = grantValid && (grantIdx == TAG_W'(g));
    assign pendAfter = pending[g] && !grantHit;
    assign collide   = lineStrobe[g] && pendAfter;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pending[g]  <= 1'b0;
        lostFlag[g] <= 1'b0;
        holdData[g] <= '0;
        holdPar[g]  <= 1'b0;
        holdFrm[g]  <= 1'b0;
      end else if (cmd.clear) begin
        pending[g]  <= 1'b0;
        lostFlag[g] <= 1'b0;
      end else begin
        if (lineStrobe[g] && !pendAfter) begin
          pending[g]  <= 1'b1;
          holdData[g] <= lineData[g*CHAR_W +: CHAR_W];
          holdPar[g]  <= lineParErr[g];
          holdFrm[g]  <= lineFrmErr[g];
        end else begin
          pending[g] <= pendAfter;
        end
        if (collide || (grantHit && dropFull)) lostFlag[g] <= 1'b1;
        else if (grantHit && doPush)           lostFlag[g] <= 1'b0;
      end
    end

    // R6: a strobe on a still-held line marks the line as having lost data
    p_collide_marks_r6: assert property (@(posedge clk) disable iff (!rstN)
      (collide && !cmd.clear) |=> lostFlag[g]);
  end

  // R5: the fill never exceeds the depth
  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FILL_W'(DEPTH));

  // R5: a full store without a pop stays full
  p_full_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && !cmd.pop && !cmd.clear) |=> (fill == FILL_W'(DEPTH)));

  // R1: an empty store with nothing pending stays empty
  p_empty_stays_r1: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && pending == '0) |=> (fill == '0));

  // R4: only a pending line can be written
  p_push_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    doPush |-> (pending != '0));
endmodule

// File: rtl/silo_ctrl.sv
module silo_ctrl
  import silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  output logic              irqRx,
  output logic              irqStorage,
  output siloCmd_t          cmd,
  input  siloEntry_t        headEntry,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] fillNext
);
  logic              rieBit, sieBit, mntBit, riFlag, siFlag;
  logic [FILL_W-1:0] alarmLvl;
  logic              csrWr, fillWr, masterClr, siSet;

  assign csrWr     = regWr && (regSel == SEL_CSR);
  assign fillWr    = regWr && (regSel == SEL_FILL);
  assign masterClr = csrWr && regWdata[B_MC];
  assign cmd.clear = masterClr;
  assign cmd.pop   = regRd && (regSel == SEL_CHAR);
  assign siSet     = (alarmLvl != '0) && (fillNext == alarmLvl) && (fillNext > fill);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rieBit   <= 1'b0;
      sieBit   <= 1'b0;
      mntBit   <= 1'b0;
      riFlag   <= 1'b0;
      siFlag   <= 1'b0;
      alarmLvl <= '0;
    end else if (masterClr) begin
      rieBit   <= 1'b0;
      sieBit   <= 1'b0;
      mntBit   <= 1'b0;
      riFlag   <= 1'b0;
      siFlag   <= 1'b0;
      alarmLvl <= '0;
    end else begin
      riFlag <= (fillNext != '0);
      if (csrWr) begin
        rieBit <= regWdata[B_RIE];
        sieBit <= regWdata[B_SIE];
        mntBit <= regWdata[B_MNT];
      end
      if (siSet)                          siFlag <= 1'b1;
      else if (csrWr && !regWdata[B_SI]) siFlag <= 1'b0;
      if (fillWr) alarmLvl <= regWdata[FILL_W-1:0];
    end
  end

  assign irqRx      = riFlag && rieBit;
  assign irqStorage = siFlag && sieBit;

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_CSR: begin
        regRdata[B_RIE] = rieBit;
        regRdata[B_RI]  = riFlag;
        regRdata[B_MNT] = mntBit;
        regRdata[B_SIE] = sieBit;
        regRdata[B_SI]  = siFlag;
      end
      SEL_CHAR: if (fill != '0) regRdata = {1'b1, headEntry};
      SEL_FILL: begin
        regRdata[8 +: FILL_W]   = fill;
        regRdata[FILL_W-1:0]    = alarmLvl;
      end
      default: regRdata = '0;
    endcase
  end

  // R7: receive flag mirrors the non-empty store
  p_ri_tracks_r7: assert property (@(posedge clk) disable iff (!rstN)
    riFlag == (fill != '0));

  // R9: master clear empties the store and drops flags and level
  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (fill == '0 && !siFlag && !riFlag && alarmLvl == '0));

  // R8: the storage flag rises only with the fill at the level
  p_si_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(siFlag) |-> (fill == alarmLvl && alarmLvl != '0));
endmodule

// File: rtl/line_rx_silo.sv
module line_rx_silo
  import silo_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NLINES-1:0]        lineStrobe,
  input  logic [NLINES*CHAR_W-1:0] lineData,
  input  logic [NLINES-1:0]        lineParErr,
  input  logic [NLINES-1:0]        lineFrmErr,
  input  logic [1:0]               regSel,
  input  logic                     regWr,
  input  logic                     regRd,
  input  logic [15:0]              regWdata,
  output logic [15:0]              regRdata,
  output logic                     irqRx,
  output logic                     irqStorage
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  siloCmd_t          cmd;
  siloEntry_t        headEntry;
  logic [FILL_W-1:0] fill, fillNext;

  silo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irqRx(irqRx),
    .irqStorage(irqStorage), .cmd(cmd), .headEntry(headEntry),
    .fill(fill), .fillNext(fillNext)
  );

  silo_datapath #(.NLINES(NLINES), .DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lineStrobe(lineStrobe),
    .lineData(lineData), .lineParErr(lineParErr), .lineFrmErr(lineFrmErr),
    .headEntry(headEntry), .fill(fill), .fillNext(fillNext)
  );
endmodule

// File: tb/test_line_rx_silo.sv
module test_line_rx_silo;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  lineStrobe = '0;
  logic [127:0] lineData = '0;
  logic [15:0]  lineParErr = '0, lineFrmErr = '0;
  logic [1:0]   regSel = '0;
  logic         regWr = 1'b0, regRd = 1'b0;
  logic [15:0]  regWdata = '0;
  logic [15:0]  regRdata;
  logic         irqRx, irqStorage;

  int checks = 0;
  int failures = 0;

  line_rx_silo i_line_rx_silo (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .lineData(lineData),
    .lineParErr(lineParErr), .lineFrmErr(lineFrmErr), .regSel(regSel),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .irqRx(irqRx), .irqStorage(irqStorage)
  );

  always #5 clk = ~clk;

  // reference model state
  logic [15:0] mPend, mLost;
  logic [9:0]  mHold [16];
  logic [15:0] mQ [$];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] sel, output logic [15:0] v);
    regSel = sel;
    #1 v = regRdata;
  endtask

  task automatic popWord(output logic [15:0] v);
    regSel = 2'd1;
    #1 v = regRdata;
    regRd = 1'b1;
    cyc();
    regRd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    regSel = sel; regWdata = d; regWr = 1'b1;
    cyc();
    regWr = 1'b0;
  endtask

  task automatic setLine(input int ln, input logic [7:0] ch, input bit p, input bit f);
    lineStrobe[ln] = 1'b1;
    lineData[ln*8 +: 8] = ch;
    lineParErr[ln] = p;
    lineFrmErr[ln] = f;
  endtask

  task automatic clrLines();
    lineStrobe = '0; lineParErr = '0; lineFrmErr = '0;
  endtask

  function automatic logic [15:0] mkWord(input int ln, input logic [7:0] ch,
                                          input bit p, input bit f, input bit o);
    return {1'b1, o, f, p, 4'(ln), ch};
  endfunction

  // one model step for the inputs present this cycle
  task automatic modelStep(input logic [15:0] s, input bit pop);
    int g = -1;
    bit full = (mQ.size() == 64);
    bit popped = pop && (mQ.size() > 0);
    logic [15:0] pAfter;
    if (popped) void'(mQ.pop_front());
    for (int i = 15; i >= 0; i--) if (mPend[i]) g = i;
    pAfter = mPend;
    if (g >= 0) begin
      pAfter[g] = 1'b0;
      if (!full || popped) begin
        mQ.push_back(mkWord(g, mHold[g][7:0], mHold[g][8], mHold[g][9], mLost[g]));
        mLost[g] = 1'b0;
      end else mLost[g] = 1'b1;
    end
    for (int i = 0; i < 16; i++) begin
      if (s[i]) begin
        if (pAfter[i]) mLost[i] = 1'b1;
        else begin
          pAfter[i] = 1'b1;
          mHold[i] = {lineFrmErr[i], lineParErr[i], lineData[i*8 +: 8]};
        end
      end
    end
    mPend = pAfter;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4711));
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // reset state
    peek(2'd0, v); chk("R10 reset csr", v, 16'h0000);
    peek(2'd2, v); chk("R8 reset fill/level", v, 16'h0000);
    peek(2'd1, v); chk("R1 reset empty word", v, 16'h0000);
    chk("R7 reset irqs", {14'd0, irqRx, irqStorage}, 16'h0000);

    // R1: read when empty
    popWord(v); chk("R1 empty pop word", v, 16'h0000);
    peek(2'd2, v); chk("R1 fill after empty pop", v, 16'h0000);

    // R2/R4 single strobe, parity error
    setLine(5, 8'hA5, 1'b1, 1'b0); cyc(); clrLines();
    peek(2'd1, v); chk("R4 not yet stored", v, 16'h0000);
    cyc();
    peek(2'd1, v); chk("R2 word format", v, 16'h95A5);
    peek(2'd0, v); chk("R7 ri set", v, 16'h0080);
    wr(2'd0, 16'h0040);
    chk("R7 irqRx on", {15'd0, irqRx}, 16'h0001);
    popWord(v); chk("R3 pop head", v, 16'h95A5);
    peek(2'd0, v); chk("R7 ri cleared on drain", v, 16'h0040);
    chk("R7 irqRx off", {15'd0, irqRx}, 16'h0000);

    // R4 simultaneous strobes, framing error on line 12
    setLine(9, 8'h09, 0, 0); setLine(2, 8'h02, 0, 0); setLine(12, 8'h0C, 0, 1);
    cyc(); clrLines(); cyc();
    peek(2'd2, v); chk("R4 one per cycle", v, 16'h0100);
    cyc(); cyc();
    peek(2'd2, v); chk("R4 all stored", v, 16'h0300);
    popWord(v); chk("R4 lowest first", v, 16'h8202);
    popWord(v); chk("R4 second", v, 16'h8909);
    popWord(v); chk("R2 framing bit", v, 16'hAC0C);

    // R8 fill level alarm
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h1000);
    setLine(0, 8'h10, 0, 0); setLine(1, 8'h11, 0, 0); setLine(7, 8'h17, 0, 0);
    cyc(); clrLines(); cyc(); cyc();
    chk("R8 below level", {15'd0, irqStorage}, 16'h0000);
    cyc();
    chk("R8 irqStorage at level", {15'd0, irqStorage}, 16'h0001);
    peek(2'd2, v); chk("R8 level/fill readback", v, 16'h0303);
    peek(2'd0, v); chk("R8 si flag", v, 16'h5080);
    wr(2'd0, 16'h5000);
    repeat (3) popWord(v);
    peek(2'd0, v); chk("R8 si sticky after drain", v, 16'h5000);
    wr(2'd0, 16'h1000);
    peek(2'd0, v); chk("R8 si cleared by write", v, 16'h1000);

    // R9 master clear, R10 maintenance bit
    wr(2'd0, 16'h1240);
    peek(2'd0, v); chk("R10 maint readback", v, 16'h1240);
    setLine(3, 8'h33, 0, 0); setLine(4, 8'h44, 0, 0); cyc(); clrLines(); cyc();
    wr(2'd0, 16'h1A40);
    peek(2'd0, v); chk("R9 csr cleared", v, 16'h0000);
    peek(2'd2, v); chk("R9 fill and level zero", v, 16'h0000);
    cyc(); cyc();
    peek(2'd1, v); chk("R9 held char dropped", v, 16'h0000);

    // R5 full store
    for (int i = 0; i < 64; i++) begin
      setLine(3, 8'(i), 0, 0); cyc();
    end
    clrLines(); cyc();
    peek(2'd2, v); chk("R5 full fill", v, 16'h4000);
    setLine(3, 8'hEE, 0, 0); setLine(4, 8'h44, 0, 0); cyc(); clrLines();
    cyc(); cyc();
    peek(2'd2, v); chk("R5 drop keeps fill", v, 16'h4000);
    popWord(v); chk("R5 head intact", v, 16'h8300);
    setLine(3, 8'h77, 0, 0); cyc(); clrLines(); cyc();
    for (int i = 1; i < 64; i++) begin
      popWord(v); chk("R5 order kept", v, 16'h8300 | 16'(i));
    end
    popWord(v); chk("R5 overrun after drop", v, 16'hC377);
    setLine(4, 8'h45, 0, 0); cyc(); clrLines(); cyc();
    popWord(v); chk("R5 other line overrun", v, 16'hC445);

    // R6 collision
    setLine(6, 8'h11, 0, 0); setLine(1, 8'h33, 0, 0); cyc(); clrLines();
    setLine(6, 8'h22, 0, 0); cyc(); clrLines(); cyc();
    popWord(v); chk("R6 lower line first", v, 16'h8133);
    popWord(v); chk("R6 held char with overrun", v, 16'hC611);
    setLine(6, 8'h99, 0, 0); cyc(); clrLines(); cyc();
    popWord(v); chk("R6 overrun cleared", v, 16'h8699);

    // random phase against the model
    wr(2'd0, 16'h0800);
    mPend = '0; mLost = '0; mQ.delete();
    for (int i = 0; i < 16; i++) mHold[i] = '0;
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] s = '0;
      bit pop;
      for (int i = 0; i < 16; i++)
        if ($urandom % 10 == 0) setLine(i, 8'($urandom), 1'($urandom), 1'($urandom));
      s = lineStrobe;
      pop = (n < 2000) ? ($urandom % 2 == 0) : ($urandom % 12 == 0);
      regSel = 2'd1; regRd = pop;
      #1 chk("R3 random head", regRdata, (mQ.size() > 0) ? mQ[0] : 16'h0000);
      modelStep(s, pop);
      cyc();
      clrLines(); regRd = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule